// File: doc/BRIEF.md
# Run-Time Programmable Parallel CRC Engine

This block folds one data word of `DATA_W` bits per clock into a `CRC_W`-bit checksum register. The feedback network is not fixed in logic. Each next-state bit is the XOR of a set of candidate terms, and each term is gated by one bit of a stored configuration matrix. Software derives the matrix for its chosen polynomial and word width, and writes it into the block one row per cycle. A full load therefore takes `CRC_W` writes, and the engine can switch to another polynomial between messages.

The register uses the direct-feedback arrangement. Data enters at the top of the register, so the checksum is ready as soon as the last message word has been accepted, with no trailing zero word. Within a word, the most significant data bit is the earliest message bit. The combining vector is `COLS = max(CRC_W, DATA_W)` bits wide, and both the register and the data word are aligned to its top. Bit-order reflection and a final XOR mask are left to the surrounding logic.

Top module: `crc_matrix_engine`

## Requirements
- R1: Starting from a zero register with a correctly derived matrix loaded, after a sequence of accepted words `crc_out` equals the remainder of (message · x^CRC_W) divided by the generator polynomial. No extra zero word is needed.
- R2: Bit `DATA_W-1` of `word_data` is the earliest message bit of its word, and bit 0 is the latest.
- R3: The combining vector is `COLS = max(CRC_W, DATA_W)` bits wide. `crc_out` occupies its top `CRC_W` bits and `word_data` is XORed into its top `DATA_W` bits, with zeros elsewhere.
- R4: While `word_valid` and `clear` are both low, `crc_out` holds its value.
- R5: `clear` sets `crc_out` to zero on the next edge. It takes priority over `word_valid`.
- R6: `row_data` bit j written to row `row_idx` = i takes effect on the next edge. A one there makes bit j of the combining vector feed next-state bit i, and a zero removes that term.
- R7: A row write issued in a cycle where `word_valid` is high is discarded, and the matrix keeps its previous contents.
- R8: After synchronous reset (`rst_n` low), `crc_out` is zero and every matrix bit is zero, so an accepted word leaves the register at zero.
- R9: Reloading all `CRC_W` rows with the matrix of another polynomial, then clearing, makes later words follow the new polynomial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Zero the checksum register |
| word_valid | input | 1 | Accept `word_data` this cycle |
| word_data | input | DATA_W | Message word, earliest bit at the MSB |
| row_we | input | 1 | Write one matrix row |
| row_idx | input | IDX_W | Row being written (next-state bit index) |
| row_data | input | COLS | Gating bits of the row, one per combining-vector bit |
| crc_out | output | CRC_W | Current checksum |

## Verification
The bench builds four engines: 4-bit checksum with 4-bit words, 32-bit with 32-bit, 4-bit with 8-bit words, and 8-bit with 4-bit words. The two equal-width builds cover the direct square matrix and a wide realistic polynomial. The two unequal builds reach both alignment branches: the register folded into the top of a wider word, and the word folded into the top of a wider register with the identity part carried in the matrix. For each build, the bench derives the matrix itself by running a bit-serial model on unit vectors, and it predicts every result with the same serial model.

// File: rtl/crc_matrix_engine.sv
module crc_matrix_engine #(
  parameter int CRC_W  = 32,
  parameter int DATA_W = 32,
  localparam int COLS  = (DATA_W > CRC_W) ? DATA_W : CRC_W,
  localparam int IDX_W = (CRC_W > 1) ? $clog2(CRC_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_data,
  input  logic              row_we,
  input  logic [IDX_W-1:0]  row_idx,
  input  logic [COLS-1:0]   row_data,
  output logic [CRC_W-1:0]  crc_out
);
  localparam logic [IDX_W:0] ROWS = CRC_W[IDX_W:0];

  logic [COLS-1:0]  mat_q [CRC_W];
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_nxt;
  logic [COLS-1:0]  mix;
  logic             row_ok;

  always_comb begin
    mix = '0;
    mix[COLS-1 -: CRC_W]  = crc_q;
    mix[COLS-1 -: DATA_W] = mix[COLS-1 -: DATA_W] ^ word_data;
  end

  for (genvar g = 0; g < CRC_W; g++) begin : g_row
    assign crc_nxt[g] = ^(mat_q[g] & mix);
  end

  assign row_ok = row_we && !word_valid && ({1'b0, row_idx} < ROWS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < CRC_W; r++) mat_q[r] <= '0;
    end else if (row_ok) begin
      mat_q[row_idx] <= row_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          crc_q <= '0;
    else if (clear)      crc_q <= '0;
    else if (word_valid) crc_q <= crc_nxt;
  end

  assign crc_out = crc_q;
endmodule

module crc_matrix_engine_chk #(
  parameter int CRC_W  = 32,
  parameter int DATA_W = 32,
  localparam int COLS  = (DATA_W > CRC_W) ? DATA_W : CRC_W,
  localparam int IDX_W = (CRC_W > 1) ? $clog2(CRC_W) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic              word_valid,
  input logic [DATA_W-1:0] word_data,
  input logic              row_we,
  input logic [IDX_W-1:0]  row_idx,
  input logic [COLS-1:0]   row_data,
  input logic [CRC_W-1:0]  crc_out,
  input logic [COLS-1:0]   row0
);
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clear |=> crc_out == '0); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!clear && !word_valid) |=> $stable(crc_out)); // R4
  AST_ZERO_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !clear && crc_out == '0 && word_data == '0) |=> crc_out == '0); // R1
  AST_ROW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (row_we && !word_valid && row_idx == '0) |=> row0 == $past(row_data)); // R6
  AST_ROW_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) (row_we && word_valid) |=> $stable(row0)); // R7
endmodule

bind crc_matrix_engine crc_matrix_engine_chk #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .word_valid(word_valid), .word_data(word_data),
  .row_we(row_we), .row_idx(row_idx), .row_data(row_data), .crc_out(crc_out), .row0(mat_q[0])
);

// File: tb/test_crc_matrix_engine.sv
module crc_harness #(
  parameter int M = 4,
  parameter int W = 4,
  parameter logic [M-1:0] P1 = '0,
  parameter logic [M-1:0] P2 = '0
) (
  input  logic clk,
  output logic done,
  output int   npass,
  output int   nfail
);
  localparam int L  = (W > M) ? W : M;
  localparam int IW = (M > 1) ? $clog2(M) : 1;

  logic rst_n = 1'b0, clear = 1'b0, vld = 1'b0, we = 1'b0, chk = 1'b0;
  logic [W-1:0]  d   = '0;
  logic [IW-1:0] idx = '0;
  logic [L-1:0]  row = '0;
  logic [M-1:0]  crc;
  logic [M-1:0]  exp_q [$];
  string         tag_q [$];
  logic [L-1:0]  bm [M];
  logic [M-1:0]  model;
  logic [M-1:0]  poly;

  initial begin done = 1'b0; npass = 0; nfail = 0; end

  crc_matrix_engine #(.CRC_W(M), .DATA_W(W)) i_crc_matrix_engine (
    .clk(clk), .rst_n(rst_n), .clear(clear), .word_valid(vld), .word_data(d),
    .row_we(we), .row_idx(idx), .row_data(row), .crc_out(crc)
  );

  function automatic logic [M-1:0] ser(input logic [M-1:0] p, input logic [M-1:0] c, input logic [W-1:0] dd);
    logic fb;
    for (int k = W - 1; k >= 0; k--) begin
      fb = c[M-1] ^ dd[k];
      c  = {c[M-2:0], 1'b0};
      if (fb) c = c ^ p;
    end
    return c;
  endfunction

  function automatic logic [M-1:0] mm(input logic [M-1:0] c, input logic [W-1:0] dd);
    logic [L-1:0] x;
    logic [M-1:0] r;
    x = '0;
    x[L-1 -: M] = c;
    x[L-1 -: W] = x[L-1 -: W] ^ dd;
    for (int i = 0; i < M; i++) r[i] = ^(bm[i] & x);
    return r;
  endfunction

  task automatic build(input logic [M-1:0] p);
    logic [L-1:0] x;
    logic [M-1:0] col;
    for (int j = 0; j < L; j++) begin
      x = '0;
      x[j] = 1'b1;
      col = (W >= M) ? ser(p, '0, x[W-1:0]) : ser(p, x[M-1:0], '0);
      for (int i = 0; i < M; i++) bm[i][j] = col[i];
    end
  endtask

  task automatic cyc(input logic v, input logic c, input logic w, input logic [IW-1:0] i,
                     input logic [L-1:0] r, input logic [W-1:0] dd, input logic dochk,
                     input logic [M-1:0] e, input string t);
    @(negedge clk);
    vld = v; clear = c; we = w; idx = i; row = r; d = dd; chk = dochk;
    if (dochk) begin exp_q.push_back(e); tag_q.push_back(t); end
  endtask

  task automatic load(input logic [M-1:0] p);
    build(p);
    poly = p;
    for (int r = 0; r < M; r++) cyc(1'b0, 1'b0, 1'b1, IW'(r), bm[r], '0, 1'b0, '0, "");
  endtask

  task automatic send(input logic [W-1:0] dd, input string t);
    model = ser(poly, model, dd);
    cyc(1'b1, 1'b0, 1'b0, '0, '0, dd, 1'b1, model, t);
  endtask

  always @(posedge clk) begin
    if (chk) begin
      #1;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL M=%0d W=%0d: result queue empty, actual %h expected none", M, W, crc);
      end else begin
        logic [M-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (crc === e) npass++;
        else begin
          nfail++;
          $display("FAIL M=%0d W=%0d %s: actual %h expected %h", M, W, t, crc, e);
        end
      end
    end
  end

  initial begin
    model = '0;
    poly = P1;
    repeat (3) @(negedge clk);
    #1;
    if (crc === '0) npass++;
    else begin nfail++; $display("FAIL M=%0d W=%0d R8: actual %h expected 0", M, W, crc); end
    @(negedge clk);
    rst_n = 1'b1;
    // R8: reset matrix is empty, so an accepted word leaves zero
    cyc(1'b1, 1'b0, 1'b0, '0, '0, '1, 1'b1, '0, "R8");
    load(P1);
    cyc(1'b0, 1'b1, 1'b0, '0, '0, '0, 1'b1, '0, "R5");
    model = '0;
    // R2: single earliest bit, then single latest bit
    send({1'b1, {(W-1){1'b0}}}, "R2");
    send({{(W-1){1'b0}}, 1'b1}, "R2");
    send('1, "R1 R3");
    for (int n = 0; n < 12; n++) send(W'($urandom), "R1 R3");
    // R4: idle cycle holds
    cyc(1'b0, 1'b0, 1'b0, '0, '0, '1, 1'b1, model, "R4");
    send(W'($urandom), "R1");
    // R7: row write alongside a word is discarded
    model = ser(poly, model, W'(32'h5A5A5A5A));
    cyc(1'b1, 1'b0, 1'b1, '0, ~bm[0], W'(32'h5A5A5A5A), 1'b1, model, "R7");
    send(W'($urandom), "R7");
    send(W'($urandom), "R7");
    // R5: clear wins over valid
    cyc(1'b1, 1'b1, 1'b0, '0, '0, '1, 1'b1, '0, "R5");
    model = '0;
    send('1, "R1");
    // R6: empty row 0 removes every term of next bit 0
    bm[0] = '0;
    cyc(1'b0, 1'b0, 1'b1, '0, '0, '0, 1'b0, '0, "");
    for (int n = 0; n < 3; n++) begin
      logic [W-1:0] dd;
      dd = W'($urandom);
      model = mm(model, dd);
      cyc(1'b1, 1'b0, 1'b0, '0, '0, dd, 1'b1, model, "R6");
    end
    // R9: reprogram and run a second message
    load(P2);
    cyc(1'b0, 1'b1, 1'b0, '0, '0, '0, 1'b1, '0, "R5");
    model = '0;
    for (int n = 0; n < 8; n++) send(W'($urandom), "R9");
    cyc(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b0, '0, "");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      nfail++;
      $display("FAIL M=%0d W=%0d: %0d results never checked, expected 0", M, W, exp_q.size());
    end
    done = 1'b1;
  end
endmodule

module test_crc_matrix_engine;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic d0, d1, d2, d3;
  int p0, p1, p2, p3, f0, f1, f2, f3;
  logic wd = 1'b0;

  crc_harness #(.M(4),  .W(4),  .P1(4'hB),          .P2(4'h3))          h_4x4  (.clk(clk), .done(d0), .npass(p0), .nfail(f0));
  crc_harness #(.M(32), .W(32), .P1(32'h04C11DB7), .P2(32'h1EDC6F41)) h_32x32(.clk(clk), .done(d1), .npass(p1), .nfail(f1));
  crc_harness #(.M(4),  .W(8),  .P1(4'hB),          .P2(4'h3))          h_4x8  (.clk(clk), .done(d2), .npass(p2), .nfail(f2));
  crc_harness #(.M(8),  .W(4),  .P1(8'h07),         .P2(8'h1D))         h_8x4  (.clk(clk), .done(d3), .npass(p3), .nfail(f3));

  initial begin
    repeat (20000) @(posedge clk);
    wd = 1'b1;
  end

  initial begin
    int pass, fail;
    wait ((d0 && d1 && d2 && d3) || wd);
    pass = p0 + p1 + p2 + p3;
    fail = f0 + f1 + f2 + f3;
    if (!(d0 && d1 && d2 && d3)) begin
      fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
    end
    $display("%0d/%0d checks passed", pass, pass + fail);
    $finish;
  end
endmodule